// File: doc/BRIEF.md
# Colour Subcarrier Oscillator with Burst Window

This block is a numerically controlled oscillator for a composite video encoder. It runs from the 27 MHz pixel-pair clock and keeps a phase accumulator that advances by a fixed step each clock. The step is picked by the selected colour standard:

- NTSC at 3.57954545 MHz.
- PAL-B/D/G/H/I at 4.43361875 MHz.
- PAL-N (Argentina) at 3.58205625 MHz.

The top bits of the phase address a quarter-wave sine table. Three lanes read that table in parallel:

- an in-phase sample;
- a quadrature sample, 90 degrees ahead;
- a burst reference sample, rotated by the burst angle of the current line.

A line-start strobe starts the burst window. The window waits a fixed number of clocks. It then opens on the next wrap of the accumulator and closes after the number of whole subcarrier cycles that the standard calls for. For the two PAL variants, each line start also flips the sign of the V axis, and the burst angle moves between +135 and +225 degrees to match. A field reset strobe returns the phase to zero and clears the window and the line alternation. The chroma modulator downstream multiplies the colour-difference samples by the sine and cosine outputs, and it inserts the burst sample while `burst_o` is high.

Top module: `csc_subcarrier_dds`

## Requirements
- R1: While `rst_ni` is low, `phase_o`, `burst_o` and `vsw_o` are held at zero.
- R2: Each clock the 32-bit accumulator advances by round(fsc / 27 MHz * 2^32). The value of fsc is chosen by `std_i`: code 0 selects 3.57954545 MHz, code 1 selects 4.43361875 MHz and code 2 selects 3.58205625 MHz. `phase_o` is the top 8 bits of the accumulator.
- R3: `sin_o` is the signed value round(127 * sin(2*pi*k/64)), where k is the top 6 bits of the accumulator. `cos_o` is the same function at k+16 (mod 64).
- R4: A field reset strobe sets the accumulator to zero for the next cycle, closes any burst window and clears `vsw_o`. It takes priority over a line start in the same cycle.
- R5: A line start is followed by BURST_DELAY clocks of waiting. The window then opens at the first accumulator wrap after that wait and closes on the N-th wrap after opening. N is 9 for codes 0 and 2 and 10 for code 1.
- R6: A line start that arrives while a wait or a window is in progress restarts the sequence. Any open window closes at once.
- R7: Under codes 1 and 2, `vsw_o` toggles on every line start. Under codes 0 and 3 it keeps its value.
- R8: While `burst_o` is high, `burst_val_o` is the table value at k plus an offset, where k is the same 6-bit index as in R3. The offset is 32 (180 degrees) for codes 0 and 3, 24 (135 degrees) for PAL with `vsw_o`=0, and 40 (225 degrees) for PAL with `vsw_o`=1. Outside the window, `burst_val_o` is zero.
- R9: Code 3 behaves as NTSC in step size, burst length and alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_i | input | 2 | Standard select: 0 NTSC, 1 PAL-B/D/G/H/I, 2 PAL-N, 3 treated as NTSC |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| field_rst_i | input | 1 | One-cycle strobe that zeroes the phase |
| phase_o | output | 8 | Top bits of the phase accumulator |
| sin_o | output | 8 | Signed in-phase sample |
| cos_o | output | 8 | Signed quadrature sample |
| burst_o | output | 1 | Burst window enable |
| burst_val_o | output | 8 | Signed burst reference sample, zero outside the window |
| vsw_o | output | 1 | V-axis sign for the current line (1 = inverted) |

## Verification
The oscillator is run under all four standard codes, each over several lines. Because the step size differs between codes, a wrong increment appears as drift in `phase_o` and in the table samples. Because the window length differs, a burst counted with the wrong N is caught. Consecutive PAL lines separate the +135 and +225 degree burst angles, and NTSC lines confirm that the alternation stays put. Further sequences exercise these cases:
- a line start inside an open window;
- a field reset in the middle of a burst;
- a field reset in the same cycle as a line start.

Between them they separate restart behaviour from plain closure, and they check the priority of the field reset.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;

   typedef enum logic [1:0] {
      STD_NTSC   = 2'd0,
      STD_PAL_BG = 2'd1,
      STD_PAL_N  = 2'd2,
      STD_RSVD   = 2'd3
   } csc_std_e;

   typedef enum logic [1:0] {
      BG_IDLE = 2'd0,
      BG_WAIT = 2'd1,
      BG_ARM  = 2'd2,
      BG_OPEN = 2'd3
   } bg_state_e;

   // subcarrier frequencies in centihertz
   localparam logic [63:0] FSC_NTSC_CHZ  = 64'd357954545;
   localparam logic [63:0] FSC_PALBG_CHZ = 64'd443361875;
   localparam logic [63:0] FSC_PALN_CHZ  = 64'd358205625;

   localparam int CYC_PAL_BG = 10;
   localparam int CYC_OTHER  = 9;

   // table geometry: 64 points per cycle, 17-entry quarter table
   localparam int LUT_AW = 6;

   function automatic logic [63:0] calc_step(input logic [63:0] fsc,
                                             input logic [63:0] fclk,
                                             input int          aw);
      logic [127:0] num;
      num = ({64'd0, fsc} << aw) + {64'd0, (fclk >> 1)};
      return 64'(num / {64'd0, fclk});
   endfunction

   function automatic logic is_pal(input logic [1:0] s);
      return (s == STD_PAL_BG) || (s == STD_PAL_N);
   endfunction

endpackage

// File: rtl/csc_phase_acc.sv
`timescale 1ns/1ps
module csc_phase_acc
   import csc_pkg::*;
#(
   parameter int          ACC_W     = 32,
   parameter int          PHASE_W   = 8,
   parameter logic [63:0] CLK_CHZ   = 64'd2700000000
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               field_rst_i,
   input  logic [1:0]         std_i,
   output logic [PHASE_W-1:0] phase_o,
   output logic               wrap_next_o
);

   localparam logic [ACC_W-1:0] STEP_NTSC  = ACC_W'(calc_step(FSC_NTSC_CHZ,  CLK_CHZ, ACC_W));
   localparam logic [ACC_W-1:0] STEP_PALBG = ACC_W'(calc_step(FSC_PALBG_CHZ, CLK_CHZ, ACC_W));
   localparam logic [ACC_W-1:0] STEP_PALN  = ACC_W'(calc_step(FSC_PALN_CHZ,  CLK_CHZ, ACC_W));

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;
   logic [ACC_W:0]   sum;

   always_comb begin
      unique case (std_i)
         STD_PAL_BG: step = STEP_PALBG;
         STD_PAL_N:  step = STEP_PALN;
         default:    step = STEP_NTSC;
      endcase
   end

   assign sum         = {1'b0, acc_q} + {1'b0, step};
   assign wrap_next_o = sum[ACC_W] & ~field_rst_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          acc_q <= '0;
      else if (field_rst_i) acc_q <= '0;
      else                  acc_q <= sum[ACC_W-1:0];
   end

   assign phase_o = acc_q[ACC_W-1 -: PHASE_W];

endmodule

// File: rtl/csc_qwave_rom.sv
`timescale 1ns/1ps
module csc_qwave_rom
   import csc_pkg::*;
#(
   parameter int AMP_W = 8
) (
   input  logic [LUT_AW-1:0]       idx_i,
   output logic signed [AMP_W-1:0] val_o
);

   function automatic logic [6:0] qtab(input logic [4:0] k);
      case (k)
         5'd0:  return 7'd0;
         5'd1:  return 7'd12;
         5'd2:  return 7'd25;
         5'd3:  return 7'd37;
         5'd4:  return 7'd49;
         5'd5:  return 7'd60;
         5'd6:  return 7'd71;
         5'd7:  return 7'd81;
         5'd8:  return 7'd90;
         5'd9:  return 7'd98;
         5'd10: return 7'd106;
         5'd11: return 7'd112;
         5'd12: return 7'd117;
         5'd13: return 7'd122;
         5'd14: return 7'd125;
         5'd15: return 7'd126;
         default: return 7'd127;
      endcase
   endfunction

   logic [4:0]             k;
   logic [6:0]             mag;
   logic signed [AMP_W-1:0] mag_s;

   // second and fourth quarters read the table backwards
   always_comb begin
      if (idx_i[4]) k = 5'd16 - {1'b0, idx_i[3:0]};
      else          k = {1'b0, idx_i[3:0]};
      mag   = qtab(k);
      mag_s = $signed({{(AMP_W-7){1'b0}}, mag});
      val_o = idx_i[5] ? -mag_s : mag_s;
   end

endmodule

// File: rtl/csc_burst_gate.sv
`timescale 1ns/1ps
module csc_burst_gate
   import csc_pkg::*;
#(
   parameter int BURST_DELAY = 16,
   parameter int DLY_W       = $clog2(BURST_DELAY + 1)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       field_rst_i,
   input  logic       line_start_i,
   input  logic [1:0] std_i,
   input  logic       wrap_next_i,
   output logic       burst_o,
   output logic       vsw_o
);

   localparam int CYC_W = $clog2(CYC_PAL_BG + 1);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(BURST_DELAY - 1);

   bg_state_e        state_q;
   logic [DLY_W-1:0] dly_q;
   logic [CYC_W-1:0] cyc_q;
   logic [CYC_W-1:0] cyc_last;

   assign cyc_last = (std_i == STD_PAL_BG) ? CYC_W'(CYC_PAL_BG - 1)
                                           : CYC_W'(CYC_OTHER - 1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= BG_IDLE;
         dly_q   <= '0;
         cyc_q   <= '0;
         vsw_o   <= 1'b0;
      end else if (field_rst_i) begin
         state_q <= BG_IDLE;
         dly_q   <= '0;
         cyc_q   <= '0;
         vsw_o   <= 1'b0;
      end else if (line_start_i) begin
         state_q <= BG_WAIT;
         dly_q   <= '0;
         cyc_q   <= '0;
         if (is_pal(std_i)) vsw_o <= ~vsw_o;
      end else begin
         unique case (state_q)
            BG_WAIT: begin
               if (dly_q == DLY_LAST) state_q <= BG_ARM;
               else                   dly_q   <= dly_q + 1'b1;
            end
            BG_ARM: begin
               if (wrap_next_i) begin
                  state_q <= BG_OPEN;
                  cyc_q   <= '0;
               end
            end
            BG_OPEN: begin
               if (wrap_next_i) begin
                  if (cyc_q == cyc_last) state_q <= BG_IDLE;
                  else                   cyc_q   <= cyc_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign burst_o = (state_q == BG_OPEN);

endmodule

// File: rtl/csc_subcarrier_dds.sv
`timescale 1ns/1ps
module csc_subcarrier_dds
   import csc_pkg::*;
#(
   parameter int          ACC_W       = 32,
   parameter int          PHASE_W     = 8,
   parameter int          AMP_W       = 8,
   parameter logic [63:0] CLK_CHZ     = 64'd2700000000,
   parameter int          BURST_DELAY = 16
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [1:0]              std_i,
   input  logic                    line_start_i,
   input  logic                    field_rst_i,
   output logic [PHASE_W-1:0]      phase_o,
   output logic signed [AMP_W-1:0] sin_o,
   output logic signed [AMP_W-1:0] cos_o,
   output logic                    burst_o,
   output logic signed [AMP_W-1:0] burst_val_o,
   output logic                    vsw_o
);

   localparam int N_LANES = 3;

   generate
      if (ACC_W < 16 || ACC_W > 48) begin : g_bad_acc
         $error("csc_subcarrier_dds: ACC_W out of range");
      end
      if (PHASE_W < LUT_AW || PHASE_W > ACC_W) begin : g_bad_phase
         $error("csc_subcarrier_dds: PHASE_W must lie between table address width and ACC_W");
      end
      if (AMP_W < 8) begin : g_bad_amp
         $error("csc_subcarrier_dds: AMP_W must be at least 8");
      end
      if (BURST_DELAY < 1) begin : g_bad_dly
         $error("csc_subcarrier_dds: BURST_DELAY must be at least 1");
      end
   endgenerate

   logic                    wrap_next;
   logic [LUT_AW-1:0]       base_idx;
   logic [LUT_AW-1:0]       burst_off;
   logic [LUT_AW-1:0]       lane_off [N_LANES];
   logic signed [AMP_W-1:0] lane_val [N_LANES];

   csc_phase_acc #(
      .ACC_W   (ACC_W),
      .PHASE_W (PHASE_W),
      .CLK_CHZ (CLK_CHZ)
   ) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .field_rst_i (field_rst_i),
      .std_i       (std_i),
      .phase_o     (phase_o),
      .wrap_next_o (wrap_next)
   );

   csc_burst_gate #(
      .BURST_DELAY (BURST_DELAY)
   ) u_gate (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .field_rst_i  (field_rst_i),
      .line_start_i (line_start_i),
      .std_i        (std_i),
      .wrap_next_i  (wrap_next),
      .burst_o      (burst_o),
      .vsw_o        (vsw_o)
   );

   assign base_idx = phase_o[PHASE_W-1 -: LUT_AW];

   // burst angle: 180 deg for NTSC, 135/225 deg alternating for PAL
   always_comb begin
      if (!is_pal(std_i)) burst_off = LUT_AW'(32);
      else if (vsw_o)     burst_off = LUT_AW'(40);
      else                burst_off = LUT_AW'(24);
   end

   assign lane_off[0] = '0;
   assign lane_off[1] = LUT_AW'(16);
   assign lane_off[2] = burst_off;

   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         logic [LUT_AW-1:0] idx;
         assign idx = base_idx + lane_off[g];
         csc_qwave_rom #(.AMP_W(AMP_W)) u_rom (
            .idx_i (idx),
            .val_o (lane_val[g])
         );
      end
   endgenerate

   assign sin_o       = lane_val[0];
   assign cos_o       = lane_val[1];
   assign burst_val_o = burst_o ? lane_val[2] : '0;

endmodule

// File: rtl/csc_dds_checker.sv
`timescale 1ns/1ps
module csc_dds_checker
   import csc_pkg::*;
#(
   parameter int PHASE_W = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [1:0]         std_i,
   input logic               line_start_i,
   input logic               field_rst_i,
   input logic [PHASE_W-1:0] phase_o,
   input logic               burst_o,
   input logic               vsw_o
);

   logic [PHASE_W-1:0] prev_ph;
   logic [7:0]         wraps_hi;
   logic               wrapped;
   logic [7:0]         exp_n;

   assign wrapped = phase_o < prev_ph;
   assign exp_n   = (std_i == STD_PAL_BG) ? 8'(CYC_PAL_BG) : 8'(CYC_OTHER);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_ph  <= '0;
         wraps_hi <= '0;
      end else begin
         prev_ph <= phase_o;
         if (!burst_o)     wraps_hi <= '0;
         else if (wrapped) wraps_hi <= wraps_hi + 8'd1;
      end
   end

   assert_reset_hold_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (phase_o == '0 && !burst_o && !vsw_o));

   assert_field_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      field_rst_i |=> (phase_o == '0 && !burst_o && !vsw_o));

   assert_open_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(burst_o) |-> wrapped);

   assert_burst_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(burst_o) && !$past(field_rst_i) && !$past(line_start_i))
      |-> (wraps_hi == exp_n && wrapped));

   assert_vsw_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_start_i && !field_rst_i && is_pal(std_i)) |=> (vsw_o != $past(vsw_o)));

   assert_vsw_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!field_rst_i && !is_pal(std_i)) |=> $stable(vsw_o));

endmodule

bind csc_subcarrier_dds csc_dds_checker #(.PHASE_W(PHASE_W)) u_dds_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .std_i        (std_i),
   .line_start_i (line_start_i),
   .field_rst_i  (field_rst_i),
   .phase_o      (phase_o),
   .burst_o      (burst_o),
   .vsw_o        (vsw_o)
);

// File: tb/test_csc_subcarrier_dds.sv
`timescale 1ns/1ps
module test_csc_subcarrier_dds;

   localparam int DLY = 16;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic [1:0]       std_i = 2'd0;
   logic             line_start_i = 1'b0;
   logic             field_rst_i = 1'b0;
   logic [7:0]       phase_o;
   logic signed [7:0] sin_o, cos_o, burst_val_o;
   logic             burst_o, vsw_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk_i = ~clk_i;

   csc_subcarrier_dds #(.BURST_DELAY(DLY)) i_csc_subcarrier_dds (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .std_i        (std_i),
      .line_start_i (line_start_i),
      .field_rst_i  (field_rst_i),
      .phase_o      (phase_o),
      .sin_o        (sin_o),
      .cos_o        (cos_o),
      .burst_o      (burst_o),
      .burst_val_o  (burst_val_o),
      .vsw_o        (vsw_o)
   );

   typedef struct {
      logic [7:0] ph;
      int         s, c, bv;
      bit         b, v;
      string      req;
   } exp_t;

   exp_t sb[$];

   // reference model state
   bit [31:0] m_acc = 0;
   int        m_st = 0, m_cnt = 0, m_cyc = 0;
   bit        m_vsw = 0;

   function automatic int sinq(input int k);
      real r;
      r = 127.0 * $sin(2.0 * 3.14159265358979 * (k & 63) / 64.0);
      if (r >= 0.0) return $rtoi(r + 0.5);
      return -$rtoi(-r + 0.5);
   endfunction

   function automatic longint incr(input logic [1:0] s);
      real f;
      f = (s == 2'd1) ? 4.43361875 : (s == 2'd2) ? 3.58205625 : 3.57954545;
      return longint'($rtoi(f / 27.0 * 4294967296.0 + 0.5));
   endfunction

   task automatic step(input bit ls, input bit fr, input logic [1:0] sd, input string req);
      bit [32:0] sum;
      bit        pal;
      int        n, k, off;
      exp_t      e;
      @(negedge clk_i);
      line_start_i = ls;
      field_rst_i  = fr;
      std_i        = sd;
      pal = (sd == 2'd1) || (sd == 2'd2);
      n   = (sd == 2'd1) ? 10 : 9;
      sum = {1'b0, m_acc} + 33'(incr(sd));
      if (fr) begin
         m_acc = 0; m_st = 0; m_cnt = 0; m_cyc = 0; m_vsw = 0;
      end else begin
         if (ls) begin
            m_st = 1; m_cnt = 0; m_cyc = 0;
            if (pal) m_vsw = ~m_vsw;
         end else begin
            case (m_st)
               1: if (m_cnt == DLY - 1) m_st = 2; else m_cnt++;
               2: if (sum[32]) begin m_st = 3; m_cyc = 0; end
               3: if (sum[32]) begin
                     if (m_cyc == n - 1) m_st = 0; else m_cyc++;
                  end
               default: ;
            endcase
         end
         m_acc = sum[31:0];
      end
      k   = int'(m_acc[31:26]);
      off = !pal ? 32 : (m_vsw ? 40 : 24);
      e.ph  = m_acc[31:24];
      e.s   = sinq(k);
      e.c   = sinq(k + 16);
      e.b   = (m_st == 3);
      e.v   = m_vsw;
      e.bv  = e.b ? sinq(k + off) : 0;
      e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pops one expectation per clock after the edge
   initial begin
      forever begin
         @(posedge clk_i);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (phase_o !== e.ph || int'(sin_o) != e.s || int'(cos_o) != e.c ||
                burst_o !== e.b || vsw_o !== e.v || int'(burst_val_o) != e.bv) begin
               fails++;
               $display("FAIL %s: got ph=%0d sin=%0d cos=%0d b=%0b v=%0b bv=%0d exp ph=%0d sin=%0d cos=%0d b=%0b v=%0b bv=%0d",
                        e.req, phase_o, sin_o, cos_o, burst_o, vsw_o, burst_val_o,
                        e.ph, e.s, e.c, e.b, e.v, e.bv);
            end
         end
      end
   end

   task automatic idle(input int cnt, input logic [1:0] sd, input string req);
      for (int i = 0; i < cnt; i++) step(0, 0, sd, req);
   endtask

   task automatic run_lines(input int lines, input logic [1:0] sd, input string req);
      for (int l = 0; l < lines; l++) begin
         step(1, 0, sd, req);
         idle(130, sd, req);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk_i);
      #1;
      checks++;
      if (phase_o !== 8'd0 || burst_o !== 1'b0 || vsw_o !== 1'b0) begin
         fails++;
         $display("FAIL R1: got ph=%0d b=%0b v=%0b exp 0 0 0", phase_o, burst_o, vsw_o);
      end
      @(posedge clk_i);
      #1 rst_ni = 1'b1;

      // R2 R3 R5 R8: NTSC over several lines, R7 alternation held
      step(0, 1, 2'd0, "R4 field reset");
      run_lines(3, 2'd0, "R2,R3,R5,R7,R8 ntsc");

      // PAL-B/D/G/H/I: 10-cycle burst, alternating angle
      step(0, 1, 2'd1, "R4 field reset");
      run_lines(4, 2'd1, "R2,R3,R5,R7,R8 pal-bg");

      // PAL-N: 9-cycle burst, alternating angle
      step(0, 1, 2'd2, "R4 field reset");
      run_lines(4, 2'd2, "R2,R3,R5,R7,R8 pal-n");

      // R6: line start inside an open window restarts the sequence
      step(1, 0, 2'd1, "R6 first line");
      idle(34, 2'd1, "R6 into burst");
      step(1, 0, 2'd1, "R6 restart");
      idle(130, 2'd1, "R6 after restart");
      step(1, 0, 2'd1, "R6 restart in wait");
      idle(5, 2'd1, "R6 wait");
      step(1, 0, 2'd1, "R6 restart in wait");
      idle(130, 2'd1, "R6 after wait restart");

      // R4: field reset in mid-burst, then together with a line start
      step(1, 0, 2'd2, "R4 line");
      idle(30, 2'd2, "R4 into burst");
      step(0, 1, 2'd2, "R4 mid-burst reset");
      idle(20, 2'd2, "R4 after reset");
      step(1, 1, 2'd2, "R4 reset beats line start");
      idle(60, 2'd2, "R4 no window after");

      // R9: code 3 acts as NTSC
      step(0, 1, 2'd3, "R9 field reset");
      run_lines(3, 2'd3, "R9 reserved code");

      // NTSC after PAL with vsw left set: R7 hold
      step(0, 1, 2'd1, "R4 reset");
      step(1, 0, 2'd1, "R7 set vsw");
      idle(10, 2'd1, "R7");
      run_lines(2, 2'd0, "R7 ntsc hold,R8");

      wait (sb.size() == 0);
      @(posedge clk_i);
      #2;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule